// File: doc/BRIEF.md
# Cache Range Maintenance Splitter

This block turns one cache maintenance request, given as a start byte address, an end byte address and a two-bit operation code, into a series of commands for a downstream maintenance engine. The start address is first rounded down to a cache-line boundary. The span from that aligned start to the end address is then rounded up to whole lines. The span is cut into range commands, and no command is larger than the engine limit minus one line. If the span is so large that it wraps the address space, within one line of the top, the block sends one whole-cache command instead. Every request ends with a sync command, and the block gives a one-cycle done pulse once that sync has been completed.

Requests and commands both use a valid/ready handshake. After a command is accepted, the block waits for a response. A positive response lets it go on to the next command. A negative response means the engine rejected the command, and the block offers the same command again with no change. Only one command is outstanding at a time.

The controller is a four-state machine:
- IDLE accepts a request and loads the aligned start, the rounded span and the first command kind.
- ISSUE presents the current command until it is accepted.
- WAIT waits for the response. A rejection takes it back to ISSUE. A completed range or whole-cache command moves it to the next command in ISSUE. A completed sync moves it to DONE.
- DONE pulses done for one cycle and returns to IDLE.

Top module: `rsm_splitter`

## Requirements
- R1: Every range command address is a multiple of LINE_BYTES. The first range command carries the request start address with its low log2(LINE_BYTES) bits cleared.
- R2: The range commands together cover the span from the aligned start to the end address, rounded up to a whole number of lines. Each range size is a non-zero multiple of LINE_BYTES.
- R3: No range command size exceeds LIMIT_BYTES - LINE_BYTES. Each range size is the smaller of the remaining span and that maximum.
- R4: The range commands are contiguous and in ascending order. Each one starts where the previous one ended.
- R5: When (end - aligned start), modulo 2^ADDR_W, is at least 2^ADDR_W - LINE_BYTES, the block sends exactly one whole-cache command and no range command. That command has address 0 and size 0.
- R6: Every request ends with exactly one sync command. done is high for exactly one cycle, in the cycle after the positive response to that sync.
- R7: A request whose rounded span is zero produces only the sync command.
- R8: After a negative response (rsp_valid=1, rsp_ok=0), the block offers the same command again in the next cycle, with the same kind, address and size.
- R9: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and all command fields stay stable.
- R10: After a command is accepted, cmd_valid is low until a response arrives. There is at most one outstanding command.
- R11: req_ready is high only in IDLE. After a request is accepted, req_ready stays low until done has been pulsed.
- R12: cmd_kind uses the encoding range=0, whole-cache=1, sync=2. cmd_op carries the request operation code on every command. cmd_addr and cmd_size are 0 for whole-cache and sync commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_start | input | ADDR_W | First byte address of the request |
| req_end | input | ADDR_W | End byte address (exclusive) |
| req_op | input | 2 | Maintenance operation code |
| cmd_valid | output | 1 | Command offered downstream |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_kind | output | 2 | 0 range, 1 whole cache, 2 sync |
| cmd_op | output | 2 | Operation code of the request |
| cmd_addr | output | ADDR_W | Range start address, 0 otherwise |
| cmd_size | output | ADDR_W | Range size in bytes, 0 otherwise |
| rsp_valid | input | 1 | Response for the outstanding command |
| rsp_ok | input | 1 | 1 completed, 0 rejected |
| done | output | 1 | One-cycle pulse at the end of a request |

## Verification
The assertions check the following on every cycle:
- the handshake rules: fields held while stalled, one outstanding command, req_ready kept low during a request;
- line alignment and the upper bound of every range size;
- the zero fields of whole-cache commands;
- the exact reissue after a rejection;
- that done follows a completed sync and lasts one cycle.

Some properties span a whole request, and only the bench's scenarios can show them:
- contiguity of the chunks and full coverage of the rounded span;
- the size of the last partial chunk;
- the whole-cache boundary at exactly one line below the wrap;
- the sync-only case for empty spans.

The bench covers these by comparing every command against a list of commands it computes for each request.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
    typedef enum logic [1:0] {
        CMD_RANGE = 2'd0,
        CMD_WHOLE = 2'd1,
        CMD_SYNC  = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/rsm_align.sv
// Aligns the start to a line, measures the span and detects the wrap fallback.
module rsm_align #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] span_bytes,
    output logic              whole_cache
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(LINE_BYTES - 1);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~LOW_MASK;
    // For a power-of-two line size, minus one line equals the line mask.
    localparam logic [ADDR_W-1:0] NEG_LINE = ADDR_W'(0) - ADDR_W'(LINE_BYTES);

    logic [ADDR_W-1:0] raw_span;

    always_comb begin
        base_addr   = start_addr & LINE_MASK;
        raw_span    = end_addr - base_addr;
        whole_cache = (raw_span >= NEG_LINE);
        span_bytes  = (raw_span + LOW_MASK) & LINE_MASK;
    end
endmodule

// File: rtl/rsm_chunk.sv
// Picks the next chunk: the smaller of the remaining span and the limit.
module rsm_chunk #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int LIMIT_BYTES = 1 << 22
) (
    input  logic [ADDR_W-1:0] remain,
    output logic [ADDR_W-1:0] chunk,
    output logic              last
);
    localparam logic [ADDR_W-1:0] MAX_CHUNK = ADDR_W'(LIMIT_BYTES - LINE_BYTES);

    always_comb begin
        last  = (remain <= MAX_CHUNK);
        chunk = last ? remain : MAX_CHUNK;
    end
endmodule

// File: rtl/rsm_splitter.sv
module rsm_splitter #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int LIMIT_BYTES = 1 << 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    input  logic [1:0]        req_op,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [ADDR_W-1:0] cmd_size,
    input  logic              rsp_valid,
    input  logic              rsp_ok,
    output logic              done
);
    import rsm_pkg::*;

    seq_state_e        state_q, state_d;
    cmd_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q, remain_q;
    logic [1:0]        op_q;

    logic [ADDR_W-1:0] base_addr, span_bytes, chunk;
    logic              whole_cache, last_chunk;

    rsm_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
        .start_addr (req_start),
        .end_addr   (req_end),
        .base_addr  (base_addr),
        .span_bytes (span_bytes),
        .whole_cache(whole_cache)
    );

    rsm_chunk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
                .LIMIT_BYTES(LIMIT_BYTES)) u_chunk (
        .remain(remain_q),
        .chunk (chunk),
        .last  (last_chunk)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: if (cmd_ready) state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) begin
                          if (rsp_ok && kind_q == CMD_SYNC) state_d = ST_DONE;
                          else                              state_d = ST_ISSUE;
                      end
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q   <= CMD_SYNC;
            addr_q   <= '0;
            remain_q <= '0;
            op_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q   <= req_op;
                    addr_q <= base_addr;
                    if (whole_cache) begin
                        kind_q   <= CMD_WHOLE;
                        remain_q <= '0;
                    end else begin
                        kind_q   <= (span_bytes == '0) ? CMD_SYNC : CMD_RANGE;
                        remain_q <= span_bytes;
                    end
                end
                ST_WAIT: if (rsp_valid && rsp_ok) begin
                    if (kind_q == CMD_RANGE) begin
                        addr_q   <= addr_q + chunk;
                        remain_q <= remain_q - chunk;
                        if (last_chunk) kind_q <= CMD_SYNC;
                    end else if (kind_q == CMD_WHOLE) begin
                        kind_q <= CMD_SYNC;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        cmd_valid = (state_q == ST_ISSUE);
        done      = (state_q == ST_DONE);
        cmd_kind  = kind_q;
        cmd_op    = op_q;
        cmd_addr  = (kind_q == CMD_RANGE) ? addr_q : '0;
        cmd_size  = (kind_q == CMD_RANGE) ? chunk  : '0;
    end
endmodule

// File: rtl/rsm_splitter_chk.sv
module rsm_splitter_chk #(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 64,
    parameter int LIMIT_BYTES = 1 << 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [1:0]        cmd_kind,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [ADDR_W-1:0] cmd_size,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              done
);
    localparam logic [ADDR_W-1:0] LOW_MASK  = ADDR_W'(LINE_BYTES - 1);
    localparam logic [ADDR_W-1:0] MAX_CHUNK = ADDR_W'(LIMIT_BYTES - LINE_BYTES);

    assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 2'd0 |-> (cmd_addr & LOW_MASK) == '0);

    assert_whole_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 2'd0 |-> (cmd_size & LOW_MASK) == '0 && cmd_size != '0);

    assert_chunk_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 2'd0 |-> cmd_size <= MAX_CHUNK);

    assert_whole_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind != 2'd0 |-> cmd_addr == '0 && cmd_size == '0);

    assert_done_after_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rsp_valid && rsp_ok && cmd_kind == 2'd2 && !cmd_valid));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_retry_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ok && !cmd_valid |=>
            cmd_valid && $stable(cmd_kind) && $stable(cmd_addr) && $stable(cmd_size));

    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=>
            cmd_valid && $stable(cmd_kind) && $stable(cmd_addr) && $stable(cmd_size));

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_valid);

    assert_busy_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    assert_ready_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (cmd_valid || done)));
endmodule

bind rsm_splitter rsm_splitter_chk #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LIMIT_BYTES(LIMIT_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .done(done)
);

// File: tb/tb_rsm_splitter.sv
module tb_rsm_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LINE = 16;
    localparam int LIMIT = 64;
    localparam logic [AW-1:0] MAXC = AW'(LIMIT - LINE);

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, cmd_ready = 0, rsp_valid = 0, rsp_ok = 0;
    logic [AW-1:0] req_start = '0, req_end = '0;
    logic [1:0] req_op = '0;
    logic req_ready, cmd_valid, done;
    logic [1:0] cmd_kind, cmd_op;
    logic [AW-1:0] cmd_addr, cmd_size;

    int checks = 0, errors = 0;
    bit reject_en = 0;
    bit finished = 0;

    typedef struct packed {
        logic [1:0]    kind;
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [AW-1:0] size;
    } exp_t;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rsm_splitter #(.ADDR_W(AW), .LINE_BYTES(LINE), .LIMIT_BYTES(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_start(req_start), .req_end(req_end), .req_op(req_op),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: computes the expected command list and sends the request
    task automatic send(input logic [AW-1:0] s, input logic [AW-1:0] e,
                        input logic [1:0] op, input string tag);
        logic [AW-1:0] a, sz, ch;
        bit seen;
        a  = s & ~AW'(LINE - 1);
        sz = e - a;
        if (sz >= (AW'(0) - AW'(LINE))) begin
            expq.push_back('{2'd1, op, '0, '0});
        end else begin
            sz = (sz + AW'(LINE - 1)) & ~AW'(LINE - 1);
            while (sz != '0) begin
                ch = (sz < MAXC) ? sz : MAXC;
                expq.push_back('{2'd0, op, a, ch});
                a  = a + ch;
                sz = sz - ch;
            end
        end
        expq.push_back('{2'd2, op, '0, '0});

        @(negedge clk);
        req_valid = 1; req_start = s; req_end = e; req_op = op;
        @(negedge clk);
        req_valid = 0;
        check(!req_ready, "R11", {tag, " ready low while busy"}, 80'(req_ready), 80'(0));
        seen = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
        check(seen, "R6", {tag, " done pulse seen"}, 80'(seen), 80'(1));
        check(expq.size() == 0, "R6", {tag, " all commands issued at done"},
              80'(expq.size()), 80'(0));
        expq.delete();
        @(negedge clk);
        check(!done && req_ready, "R6", {tag, " done lasts one cycle"},
              80'({done, req_ready}), 80'(2'b01));
    endtask

    // Monitor and responder: compares each offered command with the queue head
    initial begin : monitor
        int seq;
        bit ok;
        exp_t got;
        seq = 0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                got = '{cmd_kind, cmd_op, cmd_addr, cmd_size};
                if (expq.size() == 0)
                    check(0, "R6", "unexpected command", 80'(got), 80'(0));
                else
                    check(got == expq[0],
                          (expq[0].kind == 2'd1) ? "R5" :
                          (expq[0].kind == 2'd2) ? "R7" : "R3",
                          "command kind/op/addr/size", 80'(got), 80'(expq[0]));
                cmd_ready = 1;
                @(negedge clk);
                cmd_ready = 0;
                check(!cmd_valid, "R10", "valid drops after accept",
                      80'(cmd_valid), 80'(0));
                repeat (1 + seq % 3) @(negedge clk);
                ok = !(reject_en && (seq % 3 == 1));
                seq++;
                if (ok && expq.size() != 0) void'(expq.pop_front());
                rsp_valid = 1; rsp_ok = ok;
                @(negedge clk);
                rsp_valid = 0; rsp_ok = 0;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        report();
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && !cmd_valid && !done, "R11", "reset state",
              80'({req_ready, cmd_valid, done}), 80'(3'b100));
        // R1 R2: aligned single chunk
        send(32'h100, 32'h120, 2'd0, "aligned");
        // R1 R2 R3: unaligned ends, 0x100..0x140 -> 48 + 16
        send(32'h105, 32'h131, 2'd1, "unaligned");
        // R3 R4: multi-chunk 256 bytes -> 5x48 + 16
        send(32'h1000, 32'h1100, 2'd2, "multi");
        // R7: empty span, and start past end inside one line
        send(32'h200, 32'h200, 2'd1, "empty");
        send(32'h205, 32'h200, 2'd0, "empty_in_line");
        // R5: exactly one line below wrap, and inside the last line
        send(32'h100, 32'hF0, 2'd2, "wrap_edge");
        send(32'h100, 32'hF8, 2'd1, "wrap_inside");
        // R2: exactly one maximum chunk
        send(32'h40, 32'h70, 2'd3, "max_chunk");
        // R8: rejections during a multi-chunk request
        reject_en = 1;
        send(32'h2003, 32'h20A1, 2'd2, "retry");
        send(32'h100, 32'hF0, 2'd0, "retry_whole");
        reject_en = 0;
        // R12: op code on every command
        send(32'h3010, 32'h3020, 2'd3, "op3");
        report();
    end
endmodule